// File: doc/BRIEF.md
# Binary Bit Autocorrelation Counter Array

This block keeps a running correlation matrix of antipodal user bits over a detection window. Each user bit is a single wire: logic 1 stands for +1 and logic 0 for -1. The product of two such symbols is +1 when the wires agree and -1 when they differ, so one XNOR gate forms each product. Each matrix element is a saturating signed up/down counter. It steps up by one on agreement and down by one on disagreement.

Each accepted sample presents a current K-bit vector and the previous K-bit vector. Together they form a 2K-bit stacked vector `z`, where `z[i] = cur_bits[i]` for i < K and `z[K+m] = prev_bits[m]`. Element (i, j) correlates `z[i]` against `cur_bits[j]`. The array therefore holds both the current-by-current block and the previous-by-current cross block: 2K rows by K columns, 2K² counters in total.

A `load` pulse presets every counter to `load_val` at the start of a window. The parameter `SWEEP` selects the update schedule. With `SWEEP=0`, all counters update in the cycle a sample is taken. With `SWEEP=1`, the sample is latched and one column of 2K counters is updated per cycle over K cycles.

Top module: `acorr_counter_array`

## Requirements
- R1: After reset every counter reads 0 and `busy` is 0.
- R2: When `load` is 1 at a clock edge, every counter takes `load_val` at that edge. `load` overrides `valid`, and in sweep mode it aborts a sweep in progress, with `busy` 0 after that edge.
- R3: Element (i, j) sits at bits `[(i*K+j)*W +: W]` of `counts` as a two's-complement value. For i < K it compares `cur_bits[i]` with `cur_bits[j]`; for i >= K it compares `prev_bits[i-K]` with `cur_bits[j]`. On an update it steps +1 when the two bits are equal and -1 when they differ.
- R4: Counters saturate at +(2^(W-1)-1) and -(2^(W-1)) and never wrap.
- R5: With `SWEEP=0`, a sample taken with `valid`=1 at an edge updates all counters at that same edge.
- R6: With `SWEEP=1`, a sample taken with `valid`=1 while idle is latched at edge t. Column j of the matrix is updated at edge t+1+j. `busy` is 1 from after edge t until after edge t+K.
- R7: With `SWEEP=1`, `valid` and the bit inputs have no effect while `busy` is 1.
- R8: With `valid`=0 and `load`=0 no counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Preset all counters to `load_val` |
| load_val | input | W | Signed preset value |
| valid | input | 1 | Sample strobe for the bit vectors |
| cur_bits | input | K | Current bit vector (1 = +1, 0 = -1) |
| prev_bits | input | K | Previous bit vector |
| busy | output | 1 | Sweep in progress (always 0 when SWEEP=0) |
| counts | output | 2*K*K*W | Flattened counter matrix, element (i,j) at `(i*K+j)*W` |

## Verification
Each counter holds its whole history, so a single wrong step shows on `counts` one edge after the faulty update. That error then stays visible until the next `load`. A misrouted row or column, or a wrong agreement polarity, shows up as soon as any sample is taken with mixed bits. A wrong saturation limit shows only after repeated agreeing samples have driven a counter against its limit.

In sweep mode, a wrong column pointer shows in the partial matrix one edge after acceptance. A leaky acceptance during `busy` shows as a matrix that differs from the one built from the latched sample alone.

// File: rtl/acorr_pkg.sv
package acorr_pkg;

  // product of two antipodal bits coded 1 = +1, 0 = -1: +1 iff equal
  function automatic logic bit_agree(logic a, logic b);
    return ~(a ^ b);
  endfunction

  // one saturating step of a w-bit two's-complement counter
  function automatic int sat_next(int value, logic up, int w);
    int hi;
    int lo;
    hi = (1 << (w - 1)) - 1;
    lo = -(1 << (w - 1));
    if (up) return (value >= hi) ? hi : value + 1;
    else    return (value <= lo) ? lo : value - 1;
  endfunction

endpackage

// File: rtl/acorr_agree.sv
module acorr_agree #(
  parameter int K = 4
) (
  input  logic [2*K-1:0]   z,
  output logic [2*K*K-1:0] agree
);
  import acorr_pkg::*;
  localparam int ROWS = 2 * K;

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < K; j++) begin : g_col
      assign agree[i*K+j] = bit_agree(z[i], z[j]);
    end
  end
endmodule

// File: rtl/acorr_cell.sv
module acorr_cell #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  input  logic         agree_i,
  output logic [W-1:0] cnt
);
  import acorr_pkg::*;
  localparam int MAXV = (1 << (W - 1)) - 1;
  localparam int MINV = -(1 << (W - 1));

  int   cur_v;
  int   nxt_v;
  logic at_max;
  logic at_min;

  assign cur_v  = int'($signed(cnt));
  assign nxt_v  = sat_next(cur_v, agree_i, W);
  assign at_max = (cur_v == MAXV);
  assign at_min = (cur_v == MINV);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (en)   cnt <= nxt_v[W-1:0];
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && en && agree_i && at_max) |=> at_max);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && en && !agree_i && at_min) |=> at_min);
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !en) |=> $stable(cnt));
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/acorr_sweep_ctrl.sv
module acorr_sweep_ctrl #(
  parameter int K = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           valid,
  input  logic [K-1:0]   cur_bits,
  input  logic [K-1:0]   prev_bits,
  output logic [2*K-1:0] vec_q,
  output logic [K-1:0]   col_en,
  output logic           busy
);
  localparam int CW = (K > 1) ? $clog2(K) : 1;

  logic          active;
  logic [CW-1:0] col;
  logic          last_col;
  logic          accept;

  assign last_col = active && (col == CW'(K - 1));
  assign accept   = !active && valid && !load;
  assign busy     = active;

  always_comb begin
    for (int j = 0; j < K; j++) col_en[j] = active && (col == CW'(j));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      col    <= '0;
      vec_q  <= '0;
    end else if (load) begin
      active <= 1'b0;
      col    <= '0;
    end else if (active) begin
      if (last_col) begin
        active <= 1'b0;
        col    <= '0;
      end else begin
        col <= col + 1'b1;
      end
    end else if (accept) begin
      active <= 1'b1;
      col    <= '0;
      vec_q  <= {prev_bits, cur_bits};
    end
  end

  assert_onehot_col_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(col_en));
  assert_start_col0_R6: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && col_en[0]));
  assert_ignore_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (active && !load) |=> $stable(vec_q));
  assert_abort_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> !busy);
endmodule

// File: rtl/acorr_counter_array.sv
module acorr_counter_array #(
  parameter int K     = 4,
  parameter int W     = 8,
  parameter bit SWEEP = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [W-1:0]     load_val,
  input  logic             valid,
  input  logic [K-1:0]     cur_bits,
  input  logic [K-1:0]     prev_bits,
  output logic             busy,
  output logic [2*K*K*W-1:0] counts
);
  localparam int ROWS = 2 * K;
  localparam int NCNT = ROWS * K;

  logic [ROWS-1:0] vec;
  logic [K-1:0]    col_en;
  logic [NCNT-1:0] agree;

  if (SWEEP) begin : g_sweep
    acorr_sweep_ctrl #(.K(K)) u_ctrl (
      .clk(clk), .rst(rst), .load(load), .valid(valid),
      .cur_bits(cur_bits), .prev_bits(prev_bits),
      .vec_q(vec), .col_en(col_en), .busy(busy)
    );
  end else begin : g_par
    assign vec    = {prev_bits, cur_bits};
    assign col_en = {K{valid & ~load}};
    assign busy   = 1'b0;
  end

  acorr_agree #(.K(K)) u_agree (.z(vec), .agree(agree));

  for (genvar i = 0; i < ROWS; i++) begin : g_row
    for (genvar j = 0; j < K; j++) begin : g_col
      acorr_cell #(.W(W)) u_cell (
        .clk(clk), .rst(rst), .load(load), .load_val(load_val),
        .en(col_en[j]), .agree_i(agree[i*K+j]),
        .cnt(counts[(i*K+j)*W +: W])
      );
    end
  end
endmodule

// File: tb/acorr_counter_array_tb.sv
module acorr_counter_array_tb;
  localparam int K = 3;
  localparam int W = 4;
  localparam int N = 2 * K * K;
  localparam int HI = (1 << (W - 1)) - 1;
  localparam int LO = -(1 << (W - 1));

  logic clk = 0;
  logic rst = 1;
  logic load = 0;
  logic [W-1:0] load_val = '0;
  logic vp = 0, vs = 0;
  logic [K-1:0] cp = '0, pp = '0, cs = '0, ps = '0;
  logic busy_p, busy_s;
  logic [N*W-1:0] cnt_p, cnt_s;

  int ep[N];
  int es[N];
  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  acorr_counter_array #(.K(K), .W(W), .SWEEP(1'b0)) u_dut (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .valid(vp),
    .cur_bits(cp), .prev_bits(pp), .busy(busy_p), .counts(cnt_p));
  acorr_counter_array #(.K(K), .W(W), .SWEEP(1'b1)) u_dut_sw (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .valid(vs),
    .cur_bits(cs), .prev_bits(ps), .busy(busy_s), .counts(cnt_s));

  // bit coded 1 = +1, 0 = -1; product as integer multiply
  function automatic int step(int v, int prod);
    int r;
    r = v + prod;
    if (r > HI) r = HI;
    if (r < LO) r = LO;
    return r;
  endfunction

  task automatic model(inout int m[N], input logic [K-1:0] c, input logic [K-1:0] p,
                       input int col_lo, input int col_hi);
    for (int i = 0; i < 2 * K; i++)
      for (int j = col_lo; j <= col_hi; j++) begin
        int a, b;
        a = (i < K) ? (c[i] ? 1 : -1) : (p[i-K] ? 1 : -1);
        b = c[j] ? 1 : -1;
        m[i*K+j] = step(m[i*K+j], a * b);
      end
  endtask

  task automatic check_mat(string tag, input logic [N*W-1:0] got, input int m[N]);
    int bad;
    bad = -1;
    for (int e = 0; e < N; e++) begin
      int g;
      g = int'($signed(got[e*W +: W]));
      if (g != m[e] && bad < 0) bad = e;
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s element %0d actual %0d expected %0d", tag, bad,
               int'($signed(got[bad*W +: W])), m[bad]);
    end
  endtask

  task automatic check_bit(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual %0b expected %0b", tag, got, exp);
    end
  endtask

  task automatic set_all(inout int m[N], input int v);
    for (int e = 0; e < N; e++) m[e] = v;
  endtask

  task automatic par_sample(logic [K-1:0] c, logic [K-1:0] p, string tag);
    vp = 1; cp = c; pp = p;
    @(negedge clk);
    vp = 0;
    model(ep, c, p, 0, K - 1);
    check_mat(tag, cnt_p, ep);
  endtask

  task automatic sweep_sample(logic [K-1:0] c, logic [K-1:0] p);
    vs = 1; cs = c; ps = p;
    @(negedge clk);
    check_bit("R6 busy after accept", busy_s, 1'b1);
    cs = ~c; ps = ~p;  // R7: must be ignored while busy
    @(negedge clk);
    model(es, c, p, 0, 0);
    check_mat("R6 column 0 only", cnt_s, es);
    for (int k = 1; k < K; k++) @(negedge clk);
    model(es, c, p, 1, K - 1);
    check_mat("R7 full sweep ignores busy inputs", cnt_s, es);
    check_bit("R6 busy low after K columns", busy_s, 1'b0);
    vs = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    set_all(ep, 0);
    set_all(es, 0);
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_mat("R1 reset parallel", cnt_p, ep);
    check_mat("R1 reset sweep", cnt_s, es);
    check_bit("R1 busy reset", busy_s, 1'b0);

    // R3 R5: exhaustive sample patterns, loaded to 0 every 4 samples
    for (int v = 0; v < 64; v++) begin
      if (v % 4 == 0) begin
        load = 1; load_val = '0;
        @(negedge clk);
        load = 0; set_all(ep, 0);
      end
      par_sample(v[2:0], v[5:3], "R3 R5 parallel pattern");
    end

    // R8: idle cycles change nothing
    cp = 3'b101; pp = 3'b011;
    repeat (3) @(negedge clk);
    check_mat("R8 idle hold parallel", cnt_p, ep);
    check_mat("R8 idle hold sweep", cnt_s, es);

    // R2: load wins over valid
    load = 1; load_val = W'(5); vp = 1; vs = 1;
    @(negedge clk);
    load = 0; vp = 0; vs = 0;
    set_all(ep, 5); set_all(es, 5);
    check_mat("R2 load over valid parallel", cnt_p, ep);
    check_mat("R2 load over valid sweep", cnt_s, es);
    check_bit("R2 no sweep started", busy_s, 1'b0);

    // R4: upper saturation
    load = 1; load_val = W'(HI - 1);
    @(negedge clk);
    load = 0; set_all(ep, HI - 1);
    for (int n = 0; n < 3; n++) par_sample(3'b111, 3'b111, "R4 saturate high");
    // R4: lower saturation
    load = 1; load_val = W'(LO + 1);
    @(negedge clk);
    load = 0; set_all(ep, LO + 1);
    for (int n = 0; n < 3; n++) par_sample(3'b101, 3'b010, "R4 saturate low");

    // R6 R7: sweep over patterns
    load = 1; load_val = '0;
    @(negedge clk);
    load = 0; set_all(es, 0);
    for (int v = 0; v < 64; v += 5) sweep_sample(v[2:0], v[5:3]);

    // R2: load aborts a sweep
    vs = 1; cs = 3'b110; ps = 3'b001;
    @(negedge clk);
    vs = 0;
    @(negedge clk);
    load = 1; load_val = W'(2);
    @(negedge clk);
    load = 0; set_all(es, 2);
    check_mat("R2 load aborts sweep", cnt_s, es);
    check_bit("R2 busy cleared by load", busy_s, 1'b0);
    repeat (K + 1) @(negedge clk);
    check_mat("R2 no column after abort", cnt_s, es);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule